// File: doc/BRIEF.md
# Split 20-bit Operand Register

This block is a 20-bit holding register that sits between a 16-bit data bus and a 20-bit address space. It is the only register that holds a wide operand, and no separate memory address register exists. A wide immediate or direct address is built in one step. The low 16 bits come from the bus word that follows the opcode, and the top 4 bits come from a nibble field that the opcode carries. The decoder outside this block extracts that nibble and presents it as an input.

Two partial writes are also supported. A low-only take copies a 16-bit bus word into bits 15:0 and keeps the upper nibble. A nibble-high take writes bits 19:16 from the opcode field and keeps the low 16 bits. The nibble-high take completes in a single clock and uses no bus transfer. Every write happens on the clock edge that ends a take step. The value is read through two open strobes that model tri-state drivers. One drives the low 16 bits onto the data bus and the other drives all 20 bits onto the address output. When a strobe is idle, its output is zero and its enable is low.

Top module: `split_operand_reg`

## Requirements
- R1: After reset the stored value is 0, so with an open strobe active `data_o` and `addr_o` read 0. With no strobe active both outputs are 0 and both enables are low.
- R2: A full take (`take_full_i`=1) stores `{nib_i, bus_i}`. The nibble goes to bits 19:16 and the bus word to bits 15:0, and the new value is visible after that clock edge.
- R3: A low-only take (`take_low_i`=1, `take_full_i`=0) replaces bits 15:0 with `bus_i` and keeps bits 19:16 unchanged.
- R4: A nibble-high take (`take_nib_i`=1, `take_full_i`=0) replaces bits 19:16 with `nib_i` in one clock, keeps bits 15:0 unchanged and ignores `bus_i`.
- R5: When `take_full_i` is high, the full take wins over any low-only or nibble-high take requested in the same clock.
- R6: A low-only take and a nibble-high take in the same clock, with no full take, update both fields: the result is `{nib_i, bus_i}`.
- R7: With no take strobe active, the stored value does not change, whatever `bus_i` and `nib_i` carry.
- R8: When `open_data_i` is high, `data_o` equals bits 15:0 of the stored value and `data_oe_o` is 1. Otherwise `data_o` is 0 and `data_oe_o` is 0.
- R9: When `open_addr_i` is high, `addr_o` equals all 20 bits of the stored value and `addr_oe_o` is 1. Otherwise `addr_o` is 0 and `addr_oe_o` is 0.
- R10: Open strobes never change the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; takes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_i | input | 16 | Data bus word offered to a take |
| nib_i | input | 4 | Upper nibble field taken from the opcode |
| take_full_i | input | 1 | Write `{nib_i, bus_i}` |
| take_low_i | input | 1 | Write bits 15:0 from `bus_i` only |
| take_nib_i | input | 1 | Write bits 19:16 from `nib_i` only |
| open_data_i | input | 1 | Drive the low 16 bits onto the data bus |
| open_addr_i | input | 1 | Drive all 20 bits onto the address output |
| data_o | output | 16 | Low 16 bits when opened, else 0 |
| data_oe_o | output | 1 | Data drive enable |
| addr_o | output | 20 | Full 20 bits when opened, else 0 |
| addr_oe_o | output | 1 | Address drive enable |

## Verification
The sweep covers every opcode nibble and every combination of the three take strobes, and it varies the bus word between steps. It targets four faults:
- A design that let a partial take clear or overwrite the opposite field would show a wrong nibble or a wrong low word on the next address read.
- A design that gave the nibble-high or low take priority over the full take would show a mixed value when the strobes collide.
- A design that ignored one of two simultaneous partial takes would keep a stale field.
- Steps with only open strobes, or with no strobes, run against changing bus and nibble inputs. A design that latched on a read, or leaked the value onto an idle output, would miscompare there.

// File: rtl/split_operand_reg.sv
module split_operand_reg #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              take_full_i,
  input  logic              take_low_i,
  input  logic              take_nib_i,
  input  logic              open_data_i,
  input  logic              open_addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W+NIB_W-1:0] addr_o,
  output logic              addr_oe_o
);
  localparam int OPR_W = DATA_W + NIB_W;

  logic [DATA_W-1:0] lo_q;
  logic [NIB_W-1:0]  hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (take_full_i) begin
      lo_q <= bus_i;
      hi_q <= nib_i;
    end else begin
      if (take_low_i) lo_q <= bus_i;
      if (take_nib_i) hi_q <= nib_i;
    end
  end

  assign data_oe_o = open_data_i;
  assign addr_oe_o = open_addr_i;
  assign data_o    = open_data_i ? lo_q : '0;
  assign addr_o    = open_addr_i ? {hi_q, lo_q} : {OPR_W{1'b0}};

  // R2, R5: full take dominates
  p_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_full_i |=> (hi_q == $past(nib_i) && lo_q == $past(bus_i)));

  p_low_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_low_i && !take_full_i && !take_nib_i) |=>
      (lo_q == $past(bus_i) && $stable(hi_q)));

  p_nib_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nib_i && !take_full_i && !take_low_i) |=>
      (hi_q == $past(nib_i) && $stable(lo_q)));

  p_both_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nib_i && take_low_i && !take_full_i) |=>
      (hi_q == $past(nib_i) && lo_q == $past(bus_i)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_full_i || take_low_i || take_nib_i) |=> ($stable(hi_q) && $stable(lo_q)));

  p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_data_i |-> data_o == '0) and (!open_addr_i |-> addr_o == '0));
endmodule

// File: tb/split_operand_reg_tb.sv
module split_operand_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_i = '0;
  logic [3:0]  nib_i = '0;
  logic        take_full_i = 1'b0, take_low_i = 1'b0, take_nib_i = 1'b0;
  logic        open_data_i = 1'b0, open_addr_i = 1'b0;
  logic [15:0] data_o;
  logic        data_oe_o, addr_oe_o;
  logic [19:0] addr_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [19:0] model = '0;

  always #4 clk = ~clk;

  split_operand_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .nib_i(nib_i),
    .take_full_i(take_full_i), .take_low_i(take_low_i), .take_nib_i(take_nib_i),
    .open_data_i(open_data_i), .open_addr_i(open_addr_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .addr_o(addr_o), .addr_oe_o(addr_oe_o)
  );

  task automatic check(input string tag);
    logic [15:0] ed;
    logic [19:0] ea;
    ed = open_data_i ? model[15:0] : 16'h0;
    ea = open_addr_i ? model : 20'h0;
    n_vec++;
    if (data_o !== ed || data_oe_o !== open_data_i) begin
      n_bad++;
      $display("FAIL %s/R8: data_o=%h oe=%b expected %h oe=%b", tag, data_o, data_oe_o, ed, open_data_i);
    end
    if (addr_o !== ea || addr_oe_o !== open_addr_i) begin
      n_bad++;
      $display("FAIL %s/R9: addr_o=%h oe=%b expected %h oe=%b", tag, addr_o, addr_oe_o, ea, open_addr_i);
    end
  endtask

  task automatic step(input logic f, input logic l, input logic n,
                      input logic [15:0] b, input logic [3:0] nb,
                      input logic rd, input logic ra, input string tag);
    @(negedge clk);
    take_full_i = f; take_low_i = l; take_nib_i = n;
    bus_i = b; nib_i = nb; open_data_i = rd; open_addr_i = ra;
    @(posedge clk);
    if (f) model = {nb, b};
    else begin
      if (l) model[15:0] = b;
      if (n) model[19:16] = nb;
    end
    #1;
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle");
    open_data_i = 1'b1; open_addr_i = 1'b1; #1;
    check("R1 opened");
    @(negedge clk);
    rst_n = 1'b1;
    // R10: opening only, changing inputs, value stays 0
    step(0, 0, 0, 16'hFFFF, 4'hF, 1, 1, "R10");
    step(0, 0, 0, 16'h1234, 4'h9, 1, 0, "R10");
    for (int nb = 0; nb < 16; nb++) begin
      for (int c = 0; c < 8; c++) begin
        for (int r = 0; r < 4; r++) begin
          logic [15:0] b;
          string tag;
          b = 16'((nb * 16'h1111) ^ (c * 16'h0F0F) ^ (r * 16'h2493) ^ 16'hA5C3);
          if (c[0]) tag = (c[2:1] != 0) ? "R5" : "R2";
          else if (c[1] && c[2]) tag = "R6";
          else if (c[1]) tag = "R3";
          else if (c[2]) tag = "R4";
          else tag = "R7";
          step(c[0], c[1], c[2], b, 4'(nb), r[0], r[1], tag);
          // R10 and R7: read-only step with fresh bus/nibble, contents must hold
          step(0, 0, 0, ~b, 4'(15 - nb), 1, 1, "R10");
        end
      end
    end
    // R4 single step: low half left intact, bus ignored
    step(1, 0, 0, 16'hBEEF, 4'h3, 1, 1, "R2");
    step(0, 0, 1, 16'h0000, 4'hC, 1, 1, "R4");
    step(0, 1, 0, 16'h5A5A, 4'h0, 1, 1, "R3");
    step(1, 1, 1, 16'h0001, 4'h7, 1, 1, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule